// File: doc/BRIEF.md
# Lockable Register Write-Protection Controller

This block sits on a simple register bus. It owns two groups of configuration registers and guards writes to them. The first group holds clock-enable, power-down and clock-control settings. The second group holds pin-function select, peripheral select, peripheral-enable, push-pull output mode and drive-strength settings. A 16-bit protection register at address 0 holds one 2-bit mode field for each group. Each field switches write protection on or off for its group. A field can also freeze its own value until the next reset, so software can commit a configuration that nothing can undo afterwards.

Writes complete in one clock: the bus write strobe, address and data are sampled on the rising edge. Reads are combinational from the address. When a write is refused because its target group is protected, the block raises `writeIgnored` for exactly the next cycle. The guarded register contents are also driven out as flat vectors to the logic they configure.

Top module: `wprot_top`

## Requirements
- R1: Bits 15:4 of the protection register always read as 0, whatever value was written to them.
- R2: Protection field layout: bits 3:2 form the clock-group field and bits 1:0 form the pin-group field. Within a field, the low bit set means protection on, and the high bit set means the field is locked. So 00 is off, 01 is on, 10 is off and locked, and 11 is on and locked.
- R3: A write to address 0 loads an unlocked field from the matching data bits.
- R4: Once a field's lock bit is set, it keeps its value through every later write until reset.
- R5: The fields lock independently. A write to address 0 still updates an unlocked field when the other field is locked.
- R6: Reset clears the protection register and every guarded register to 0.
- R7: While the clock-group field is protecting, a write to addresses 1 to 4 (clock group) leaves the register unchanged.
- R8: While the pin-group field is protecting, a write to addresses 5 to 9 (pin group) leaves the register unchanged.
- R9: A write to an unprotected guarded register takes effect at that clock edge. From the next cycle the new value appears both on `busRdata` and on the configuration output.
- R10: Reads of every address return the current contents in every protection mode.
- R11: `writeIgnored` is high for exactly the one cycle after a blocked write, and low at all other times.
- R12: Addresses 10 to 15 are unmapped. They read as 0, and writes to them change nothing and raise no `writeIgnored`. A write to one group never alters the other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe, sampled on the clock edge |
| busAddr | input | ADDR_W (4) | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr`, combinational |
| writeIgnored | output | 1 | One-cycle pulse after a blocked write |
| clkCfg | output | CLK_REGS*16 (64) | Clock-group registers; the register at address 1 is in the low bits |
| pinCfg | output | PIN_REGS*16 (80) | Pin-group registers; the register at address 5 is in the low bits |

## Verification
The assertions check several rules on every cycle:
- the reserved bits read back as 0;
- a locked field never changes;
- a write into a protecting group leaves that group's outputs stable and raises the pulse;
- the pulse only ever follows a bus write;
- a clock-group write leaves the pin group untouched.

Only the bench scenarios can show the positive effects:
- unprotected writes and unlocked field updates really take hold;
- one field still changes while the other is locked;
- a reset releases a lock;
- unmapped addresses read as 0.

A reference model in the bench compares these against the design under both directed and random traffic.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int DATA_W = 16;
  localparam int FIELD_W = 2;
  localparam int SLOT_W = 5;

  typedef struct packed {
    logic              protWe;
    logic              bankWe;
    logic [SLOT_W-1:0] slot;
    logic              blocked;
  } wrStrobe_t;
endpackage

// File: rtl/wprot_field.sv
module wprot_field
  import wprot_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               we,
  input  logic [FIELD_W-1:0] din,
  output logic [FIELD_W-1:0] q
);
  // q[1] = lock, q[0] = protect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= '0;
    end else if (we && !q[1]) begin
      q <= din;
    end
  end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CLK_REGS = 4,
  parameter int PIN_REGS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output wrStrobe_t         strobe,
  output logic [3:0]        protFields,
  output logic              writeIgnored
);
  localparam logic [ADDR_W-1:0] CLK_LO = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] CLK_HI = ADDR_W'(CLK_REGS);
  localparam logic [ADDR_W-1:0] PIN_LO = ADDR_W'(CLK_REGS + 1);
  localparam logic [ADDR_W-1:0] PIN_HI = ADDR_W'(CLK_REGS + PIN_REGS);

  logic inClk, inPin, isProt;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    isProt = (busAddr == '0);
    inClk  = (busAddr >= CLK_LO) && (busAddr <= CLK_HI);
    inPin  = (busAddr >= PIN_LO) && (busAddr <= PIN_HI);
    offset = busAddr - CLK_LO;
    strobe.protWe  = busWr && isProt;
    strobe.blocked = busWr && ((inClk && protFields[2]) || (inPin && protFields[0]));
    strobe.bankWe  = busWr && (inClk || inPin) && !strobe.blocked;
    strobe.slot    = SLOT_W'(offset);
  end

  // field 0 = pin group (bits 1:0), field 1 = clock group (bits 3:2)
  for (genvar g = 0; g < 2; g++) begin : gField
    wprot_field u_field (
      .clk  (clk),
      .rstN (rstN),
      .we   (strobe.protWe),
      .din  (busWdata[g*FIELD_W +: FIELD_W]),
      .q    (protFields[g*FIELD_W +: FIELD_W])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeIgnored <= 1'b0;
    end else begin
      writeIgnored <= strobe.blocked;
    end
  end
endmodule

// File: rtl/wprot_bank.sv
module wprot_bank
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CLK_REGS = 4,
  parameter int PIN_REGS = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  wrStrobe_t                    strobe,
  input  logic [DATA_W-1:0]            busWdata,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [3:0]                   protFields,
  output logic [DATA_W-1:0]            busRdata,
  output logic [CLK_REGS*DATA_W-1:0]   clkCfg,
  output logic [PIN_REGS*DATA_W-1:0]   pinCfg
);
  localparam int NREG = CLK_REGS + PIN_REGS;

  logic [NREG*DATA_W-1:0] bankFlat;

  for (genvar i = 0; i < NREG; i++) begin : gReg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '0;
      end else if (strobe.bankWe && strobe.slot == SLOT_W'(i)) begin
        q <= busWdata;
      end
    end
    assign bankFlat[i*DATA_W +: DATA_W] = q;
  end

  assign clkCfg = bankFlat[CLK_REGS*DATA_W-1:0];
  assign pinCfg = bankFlat[NREG*DATA_W-1:CLK_REGS*DATA_W];

  always_comb begin
    busRdata = '0;
    if (busAddr == '0) begin
      busRdata = {{(DATA_W-4){1'b0}}, protFields};
    end
    for (int i = 0; i < NREG; i++) begin
      if (busAddr == ADDR_W'(i + 1)) begin
        busRdata = bankFlat[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/wprot_top.sv
module wprot_top
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CLK_REGS = 4,
  parameter int PIN_REGS = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWr,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [15:0]                busWdata,
  output logic [15:0]                busRdata,
  output logic                       writeIgnored,
  output logic [CLK_REGS*16-1:0]     clkCfg,
  output logic [PIN_REGS*16-1:0]     pinCfg
);
  wrStrobe_t  strobe;
  logic [3:0] protFields;

  wprot_ctrl #(.ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS), .PIN_REGS(PIN_REGS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .busWr        (busWr),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .strobe       (strobe),
    .protFields   (protFields),
    .writeIgnored (writeIgnored)
  );

  wprot_bank #(.ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS), .PIN_REGS(PIN_REGS)) u_bank (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .busAddr    (busAddr),
    .protFields (protFields),
    .busRdata   (busRdata),
    .clkCfg     (clkCfg),
    .pinCfg     (pinCfg)
  );
endmodule

// File: rtl/wprot_checker.sv
module wprot_checker #(
  parameter int ADDR_W   = 4,
  parameter int CLK_REGS = 4,
  parameter int PIN_REGS = 5
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busWr,
  input logic [ADDR_W-1:0]      busAddr,
  input logic [15:0]            busRdata,
  input logic                   writeIgnored,
  input logic [CLK_REGS*16-1:0] clkCfg,
  input logic [PIN_REGS*16-1:0] pinCfg,
  input logic [3:0]             protFields
);
  logic clkHit, pinHit;
  always_comb begin
    clkHit = busWr && (busAddr >= ADDR_W'(1)) && (busAddr <= ADDR_W'(CLK_REGS));
    pinHit = busWr && (busAddr >= ADDR_W'(CLK_REGS + 1)) &&
             (busAddr <= ADDR_W'(CLK_REGS + PIN_REGS));
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == '0) |-> (busRdata[15:4] == '0)); // R1
  AST_CLK_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    protFields[3] |=> $stable(protFields[3:2])); // R4
  AST_PIN_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    protFields[1] |=> $stable(protFields[1:0])); // R4
  AST_CLK_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (clkHit && protFields[2]) |=> ($stable(clkCfg) && writeIgnored)); // R7
  AST_PIN_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (pinHit && protFields[0]) |=> ($stable(pinCfg) && writeIgnored)); // R8
  AST_IGN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    writeIgnored |-> $past(busWr)); // R11
  AST_GROUP_ISOLATE: assert property (@(posedge clk) disable iff (!rstN)
    clkHit |=> $stable(pinCfg)); // R12
endmodule

bind wprot_top wprot_checker #(.ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS), .PIN_REGS(PIN_REGS)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busWr        (busWr),
  .busAddr      (busAddr),
  .busRdata     (busRdata),
  .writeIgnored (writeIgnored),
  .clkCfg       (clkCfg),
  .pinCfg       (pinCfg),
  .protFields   (protFields)
);

// File: tb/wprot_top_bench.sv
`timescale 1ns/1ps
module wprot_top_bench;
  localparam int ADDR_W = 4;
  localparam int CR = 4;
  localparam int PR = 5;
  localparam int NREG = CR + PR;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic writeIgnored;
  logic [CR*16-1:0] clkCfg;
  logic [PR*16-1:0] pinCfg;

  int nChecks = 0;
  int nErrors = 0;
  logic [3:0] mProt;
  logic [15:0] mReg [NREG];

  always #2.5 clk = ~clk;

  wprot_top #(.ADDR_W(ADDR_W), .CLK_REGS(CR), .PIN_REGS(PR)) u_wprot_top (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .writeIgnored(writeIgnored), .clkCfg(clkCfg), .pinCfg(pinCfg)
  );

  function automatic bit isBlocked(int a);
    return (a >= 1 && a <= CR && mProt[2]) || (a > CR && a <= NREG && mProt[0]);
  endfunction

  function automatic logic [15:0] expRead(int a);
    if (a == 0) return {12'b0, mProt};
    if (a >= 1 && a <= NREG) return mReg[a-1];
    return 16'h0;
  endfunction

  task automatic check(bit ok, string req, logic [159:0] act, logic [159:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyModel(int a, logic [15:0] d);
    if (a == 0) begin
      if (!mProt[3]) mProt[3:2] = d[3:2];
      if (!mProt[1]) mProt[1:0] = d[1:0];
    end else if (a <= NREG && !isBlocked(a)) begin
      mReg[a-1] = d;
    end
  endtask

  task automatic doWrite(int a, logic [15:0] d, string req);
    bit expIgn;
    @(negedge clk);
    busWr = 1'b1; busAddr = ADDR_W'(a); busWdata = d;
    expIgn = isBlocked(a);
    @(posedge clk);
    applyModel(a, d);
    @(negedge clk);
    busWr = 1'b0;
    check(writeIgnored == expIgn, req, 160'(writeIgnored), 160'(expIgn));
  endtask

  task automatic readCheck(int a, string req);
    logic [CR*16-1:0] ec;
    logic [PR*16-1:0] ep;
    @(negedge clk);
    busAddr = ADDR_W'(a);
    #1;
    check(busRdata == expRead(a), req, 160'(busRdata), 160'(expRead(a)));
    check(writeIgnored == 1'b0, {req, " R11 pulse low"}, 160'(writeIgnored), 160'(0));
    for (int i = 0; i < CR; i++) ec[i*16 +: 16] = mReg[i];
    for (int i = 0; i < PR; i++) ep[i*16 +: 16] = mReg[CR+i];
    check(clkCfg == ec && pinCfg == ep, {req, " R9 cfg outputs"},
          160'({clkCfg, pinCfg}), 160'({ec, ep}));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    busWr = 1'b0;
    mProt = '0;
    for (int i = 0; i < NREG; i++) mReg[i] = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    int a;
    logic [15:0] d;
    void'($urandom(32'd20240611));
    doReset();
    for (int i = 0; i < 16; i++) readCheck(i, "R6 reset state");
    doWrite(1, 16'h1234, "R9 unprotected write");
    readCheck(1, "R9 readback");
    doWrite(0, 16'h0001, "R3 pin protect on");
    readCheck(0, "R2 field layout");
    doWrite(5, 16'hBEEF, "R8 pin write blocked");
    readCheck(5, "R8 pin unchanged");
    doWrite(2, 16'h5555, "R9 clk write while pin protected");
    readCheck(2, "R10 read while protected");
    doWrite(0, 16'h0004, "R3 clk protect on");
    doWrite(3, 16'hAAAA, "R7 clk write blocked");
    readCheck(3, "R7 clk unchanged");
    doWrite(6, 16'h7777, "R9 pin write allowed");
    readCheck(6, "R10 read pin");
    doWrite(0, 16'hFFF0, "R1 reserved bits");
    readCheck(0, "R1 reserved read zero");
    doWrite(0, 16'h0008, "R4 clk lock off");
    doWrite(0, 16'h0005, "R5 pin changes clk locked");
    readCheck(0, "R5 independent lock");
    doWrite(1, 16'h4321, "R9 locked-off group writable");
    doWrite(5, 16'h1111, "R8 blocked again");
    doWrite(0, 16'h000F, "R4 pin locks on");
    doWrite(0, 16'h0000, "R4 both locked");
    readCheck(0, "R4 lock holds");
    doWrite(12, 16'hCAFE, "R12 unmapped write");
    readCheck(12, "R12 unmapped read");
    doReset();
    readCheck(0, "R6 reset releases lock");
    readCheck(1, "R6 reset clears bank");
    for (int it = 0; it < 2000; it++) begin
      if (it % 150 == 149) doReset();
      a = ($urandom % 5 == 0) ? 0 : int'($urandom % 16);
      d = 16'($urandom);
      if (a == 0 && ($urandom % 3 != 0)) d[3] = 1'b0;
      if (a == 0 && ($urandom % 3 != 0)) d[1] = 1'b0;
      doWrite(a, d, "R11 random write pulse");
      readCheck(int'($urandom % 16), "R10 random read");
    end
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule